// File: doc/BRIEF.md
# Two-Port Interleaved Banked Data Store

This block is the data array of a cache that must accept two accesses per clock without paying for multiported cells. Its words are split between two single-ported banks by one bit of the word address. Even words live in bank 0 and odd words in bank 1, so the total storage equals that of one plain array. Each bank holds half of it. An input crossbar steers each port's request to the bank its address selects. An output crossbar returns each bank's read word to the port that issued the read.

Each port has a valid/ready request channel that carries a write flag, a byte address and write data. It also has a response channel that carries a valid flag and read data. Requests to different banks are both taken in the same cycle. When both ports want the same bank, one is granted and the other sees ready low and must hold its request. The winner alternates from one conflict to the next. A saturating counter reports how many cycles conflicts have cost. Tag checking, miss handling and refill belong to other blocks.

Top module: `dual_bank_store`

## Requirements
- R1: The bank is chosen by address bit OFF_W (bit 2 for 32-bit data): 0 selects bank 0, 1 selects bank 1. The word within the bank is taken from the next IDX_W bits, and all higher address bits are ignored, so addresses that differ only there alias to the same word.
- R2: A write accepted on either port stores its data. A later read of the same word from either port returns that data.
- R3: When both ports are valid and their addresses select different banks, both ports are ready in that cycle.
- R4: When both ports are valid and select the same bank, exactly one of them is ready in that cycle.
- R5: The first conflict after reset is won by port 0. Every conflict cycle hands priority to the other port, so a port that lost and holds its request wins the next conflict.
- R6: A read accepted in cycle t gives rvalid high with its data in cycle t+1 on the same port. A write, or a cycle with no accepted read, gives rvalid low in the next cycle.
- R7: When both ports read in one cycle with port 0 in bank 1 and port 1 in bank 0, each port receives the word from the bank its own address selected.
- R8: conflict_cycles is zero after reset. It rises by one in each conflict cycle, stays at its all-ones value once reached, and otherwise holds.
- R9: During and straight after reset, both rvalid outputs are low and both ready outputs are high.
- R10: A port that is valid while the other port is idle is always ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_valid | input | 1 | Port 0 request valid |
| p0_ready | output | 1 | Port 0 request accepted this cycle |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_wdata | input | DATA_W | Port 0 write data |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_rdata | output | DATA_W | Port 0 read data |
| p1_valid | input | 1 | Port 1 request valid |
| p1_ready | output | 1 | Port 1 request accepted this cycle |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | DATA_W | Port 1 read data |
| conflict_cycles | output | CNT_W | Saturating count of bank-conflict cycles |

## Verification
Two accesses can land in the same cycle either in different banks, where both must pass the crossbars at once, or in the same bank, where the arbiter must pick one. Random stimulus with a third of the accesses being writes and unrestricted addresses produces both cases in roughly equal numbers. Losing requests are held, as the handshake requires. Directed cycles cover crossed reads, back-to-back conflicts on one bank and aliased addresses. Each cycle the bench predicts both ready values from its own priority bit and compares them. One cycle later it compares the responses with a word-level memory model and the conflict counter with a saturating count.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   localparam int NPORTS = 2;
   localparam int NBANKS = 2;

   typedef enum logic {
      PORT_A = 1'b0,
      PORT_B = 1'b1
   } port_e;

   function automatic port_e other_port(input port_e p);
      return (p == PORT_A) ? PORT_B : PORT_A;
   endfunction
endpackage

// File: rtl/dbs_bank.sv
module dbs_bank #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int ROWS = 1 << IDX_W;

   logic [DATA_W-1:0] cells [ROWS];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) cells[idx] <= wdata;
         else    rdata      <= cells[idx];
      end
   end
endmodule

// File: rtl/dbs_arbiter.sv
module dbs_arbiter
   import dbs_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] req_v,
   input  logic [NPORTS-1:0] req_bank,
   output logic [NPORTS-1:0] port_ready,
   output logic [NPORTS-1:0] grant,
   output logic [CNT_W-1:0]  conflict_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   port_e prio;
   logic  conflict;

   assign conflict = (&req_v) && (req_bank[0] == req_bank[1]);

   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         port_ready[p] = !conflict || (prio == port_e'(p));
      end
      grant = req_v & port_ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio         <= PORT_A;
         conflict_cnt <= '0;
      end else if (conflict) begin
         prio <= other_port(prio);
         if (conflict_cnt != CNT_MAX) conflict_cnt <= conflict_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dual_bank_store.sv
module dual_bank_store
   import dbs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12,
   parameter int WORDS  = 64,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p0_valid,
   output logic              p0_ready,
   input  logic              p0_we,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic [DATA_W-1:0] p0_wdata,
   output logic              p0_rvalid,
   output logic [DATA_W-1:0] p0_rdata,
   input  logic              p1_valid,
   output logic              p1_ready,
   input  logic              p1_we,
   input  logic [ADDR_W-1:0] p1_addr,
   input  logic [DATA_W-1:0] p1_wdata,
   output logic              p1_rvalid,
   output logic [DATA_W-1:0] p1_rdata,
   output logic [CNT_W-1:0]  conflict_cycles
);
   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int IDX_W = $clog2(WORDS / NBANKS);
   localparam int IDX_LO = OFF_W + 1;

   if ((DATA_W < 8) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 8");
   end
   if ((WORDS < 4) || ((WORDS & (WORDS - 1)) != 0)) begin : g_bad_words
      $error("WORDS must be a power of two of at least 4");
   end
   if (ADDR_W < IDX_LO + IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for WORDS and DATA_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [NPORTS-1:0] req_v, req_we, req_bank, port_ready, grant;
   logic [ADDR_W-1:0] req_addr  [NPORTS];
   logic [DATA_W-1:0] req_wdata [NPORTS];
   logic [DATA_W-1:0] bank_rd   [NBANKS];
   logic [NPORTS-1:0] rvalid_q, src_q;

   assign req_v       = {p1_valid, p0_valid};
   assign req_we      = {p1_we, p0_we};
   assign req_addr[0] = p0_addr;
   assign req_addr[1] = p1_addr;
   assign req_wdata[0] = p0_wdata;
   assign req_wdata[1] = p1_wdata;

   for (genvar p = 0; p < NPORTS; p++) begin : g_sel
      assign req_bank[p] = req_addr[p][OFF_W];
   end

   dbs_arbiter #(.CNT_W(CNT_W)) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_v        (req_v),
      .req_bank     (req_bank),
      .port_ready   (port_ready),
      .grant        (grant),
      .conflict_cnt (conflict_cycles)
   );

   assign p0_ready = port_ready[0];
   assign p1_ready = port_ready[1];

   // input crossbar: each bank takes the granted port aimed at it
   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic              hit0, hit1, en;
      logic              src;
      logic              we;
      logic [IDX_W-1:0]  idx;
      logic [DATA_W-1:0] wd;

      always_comb begin
         hit0 = grant[0] && (req_bank[0] == 1'(b));
         hit1 = grant[1] && (req_bank[1] == 1'(b));
         en   = hit0 || hit1;
         src  = hit1;
         we   = req_we[src];
         idx  = req_addr[src][IDX_LO +: IDX_W];
         wd   = req_wdata[src];
      end

      dbs_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
         .clk   (clk),
         .en    (en),
         .we    (we),
         .idx   (idx),
         .wdata (wd),
         .rdata (bank_rd[b])
      );
   end

   // output crossbar: remember which bank served each port's read
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= '0;
         src_q    <= '0;
      end else begin
         rvalid_q <= grant & ~req_we;
         for (int p = 0; p < NPORTS; p++) begin
            if (grant[p]) src_q[p] <= req_bank[p];
         end
      end
   end

   assign p0_rvalid = rvalid_q[0];
   assign p1_rvalid = rvalid_q[1];
   assign p0_rdata  = bank_rd[src_q[0]];
   assign p1_rdata  = bank_rd[src_q[1]];
endmodule

// File: rtl/dbs_store_chk.sv
module dbs_store_chk #(
   parameter int ADDR_W = 12,
   parameter int OFF_W  = 2,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              p0_valid,
   input logic              p0_ready,
   input logic              p0_we,
   input logic [ADDR_W-1:0] p0_addr,
   input logic              p0_rvalid,
   input logic              p1_valid,
   input logic              p1_ready,
   input logic              p1_we,
   input logic [ADDR_W-1:0] p1_addr,
   input logic              p1_rvalid,
   input logic [CNT_W-1:0]  conflict_cycles
);
   logic both, same, conf, rd0, rd1;
   assign both = p0_valid && p1_valid;
   assign same = p0_addr[OFF_W] == p1_addr[OFF_W];
   assign conf = both && same;
   assign rd0  = p0_valid && p0_ready && !p0_we;
   assign rd1  = p1_valid && p1_ready && !p1_we;

   AST_SPLIT_BOTH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      both && !same |-> p0_ready && p1_ready); // R3
   AST_CONFLICT_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      conf |-> $countones({p0_ready, p1_ready}) == 1); // R4
   AST_WINNER_TOGGLES_A: assert property (@(posedge clk) disable iff (!rst_n)
      conf && p0_ready |=> !conf || p1_ready); // R5
   AST_WINNER_TOGGLES_B: assert property (@(posedge clk) disable iff (!rst_n)
      conf && p1_ready |=> !conf || p0_ready); // R5
   AST_LONE_PORT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      p0_valid != p1_valid |-> p0_ready && p1_ready); // R10
   AST_READ_RESPONDS_A: assert property (@(posedge clk) disable iff (!rst_n)
      rd0 |=> p0_rvalid); // R6
   AST_READ_RESPONDS_B: assert property (@(posedge clk) disable iff (!rst_n)
      rd1 |=> p1_rvalid); // R6
   AST_NO_STRAY_RSP_A: assert property (@(posedge clk) disable iff (!rst_n)
      !rd0 |=> !p0_rvalid); // R6
   AST_NO_STRAY_RSP_B: assert property (@(posedge clk) disable iff (!rst_n)
      !rd1 |=> !p1_rvalid); // R6
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      conf && !(&conflict_cycles) |=>
         conflict_cycles == CNT_W'($past(conflict_cycles) + 1'b1)); // R8
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !conf || (&conflict_cycles) |=> $stable(conflict_cycles)); // R8
endmodule

bind dual_bank_store dbs_store_chk #(
   .ADDR_W (ADDR_W),
   .OFF_W  (OFF_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .p0_valid        (p0_valid),
   .p0_ready        (p0_ready),
   .p0_we           (p0_we),
   .p0_addr         (p0_addr),
   .p0_rvalid       (p0_rvalid),
   .p1_valid        (p1_valid),
   .p1_ready        (p1_ready),
   .p1_we           (p1_we),
   .p1_addr         (p1_addr),
   .p1_rvalid       (p1_rvalid),
   .conflict_cycles (conflict_cycles)
);

// File: tb/sim_dual_bank_store.sv
module sim_dual_bank_store;
   localparam int DW    = 32;
   localparam int AW    = 12;
   localparam int WORDS = 64;
   localparam int CW    = 4;
   localparam int OFF   = 2;
   localparam int WB    = 6;   // bits naming a word: bank bit plus index
   localparam int CMAX  = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          r_v  [2];
   logic          r_we [2];
   logic [AW-1:0] r_a  [2];
   logic [DW-1:0] r_d  [2];

   logic          p0_ready, p1_ready, p0_rvalid, p1_rvalid;
   logic [DW-1:0] p0_rdata, p1_rdata;
   logic [CW-1:0] conflict_cycles;

   dual_bank_store #(.DATA_W(DW), .ADDR_W(AW), .WORDS(WORDS), .CNT_W(CW)) u0 (
      .clk (clk), .rst_n (rst_n),
      .p0_valid (r_v[0]), .p0_ready (p0_ready), .p0_we (r_we[0]),
      .p0_addr (r_a[0]), .p0_wdata (r_d[0]),
      .p0_rvalid (p0_rvalid), .p0_rdata (p0_rdata),
      .p1_valid (r_v[1]), .p1_ready (p1_ready), .p1_we (r_we[1]),
      .p1_addr (r_a[1]), .p1_wdata (r_d[1]),
      .p1_rvalid (p1_rvalid), .p1_rdata (p1_rdata),
      .conflict_cycles (conflict_cycles)
   );

   int total = 0;
   int fails = 0;

   logic [DW-1:0] mdl [WORDS];
   bit            prio = 1'b0;
   int            cnt  = 0;
   bit            acc  [2];

   function automatic bit bank_of(input logic [AW-1:0] a);
      return a[OFF];
   endfunction

   function automatic int word_of(input logic [AW-1:0] a);
      return int'(a[OFF +: WB]);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act,
                      input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   // inputs are set after a falling edge; this runs one clock
   task automatic cycle();
      bit conf, both, erdy[2], erv[2];
      logic [DW-1:0] erd[2];
      string lbl;
      #1;
      both = r_v[0] && r_v[1];
      conf = both && (bank_of(r_a[0]) == bank_of(r_a[1]));
      for (int p = 0; p < 2; p++) erdy[p] = !conf || (prio == p[0]);
      lbl = conf ? "R4/R5" : (both ? "R3" : "R10");
      chk(p0_ready == erdy[0], {lbl, " p0_ready"}, p0_ready, erdy[0]);
      chk(p1_ready == erdy[1], {lbl, " p1_ready"}, p1_ready, erdy[1]);
      for (int p = 0; p < 2; p++) begin
         acc[p] = r_v[p] && erdy[p];
         erv[p] = acc[p] && !r_we[p];
         erd[p] = mdl[word_of(r_a[p])];
      end
      for (int p = 0; p < 2; p++) begin
         if (acc[p] && r_we[p]) mdl[word_of(r_a[p])] = r_d[p];
      end
      if (conf) begin
         prio = !prio;
         if (cnt < CMAX) cnt++;
      end
      @(posedge clk);
      @(negedge clk);
      lbl = (erv[0] && erv[1]) ? "R7" : "R2";
      chk(p0_rvalid == erv[0], "R6 p0_rvalid", p0_rvalid, erv[0]);
      chk(p1_rvalid == erv[1], "R6 p1_rvalid", p1_rvalid, erv[1]);
      if (erv[0]) chk(p0_rdata == erd[0], {lbl, " p0_rdata"}, p0_rdata, erd[0]);
      if (erv[1]) chk(p1_rdata == erd[1], {lbl, " p1_rdata"}, p1_rdata, erd[1]);
      chk(int'(conflict_cycles) == cnt, "R8 conflict_cycles",
          conflict_cycles, cnt);
   endtask

   task automatic put(input int p, input bit v, input bit we,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
      r_v[p] = v; r_we[p] = we; r_a[p] = a; r_d[p] = d;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int p = 0; p < 2; p++) put(p, 1'b0, 1'b0, '0, '0);
      repeat (3) @(negedge clk);
      #1;
      // R9: held in reset
      chk(!p0_rvalid && !p1_rvalid, "R9 rvalid in reset",
          {p0_rvalid, p1_rvalid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(conflict_cycles == '0, "R8 count after reset", conflict_cycles, 0);
      chk(p0_ready && p1_ready, "R9 ready after reset", {p0_ready, p1_ready}, 3);
      chk(!p0_rvalid && !p1_rvalid, "R9 rvalid after reset",
          {p0_rvalid, p1_rvalid}, 0);
      #1;

      // fill every word: port 0 even words, port 1 odd words (R2, R3)
      for (int k = 0; k < WORDS / 2; k++) begin
         put(0, 1'b1, 1'b1, AW'((2 * k) << OFF), $urandom);
         put(1, 1'b1, 1'b1, AW'((2 * k + 1) << OFF), $urandom);
         cycle();
      end

      // R7: crossed reads in one cycle
      put(0, 1'b1, 1'b0, AW'(5 << OFF), '0);
      put(1, 1'b1, 1'b0, AW'(8 << OFF), '0);
      cycle();

      // R1: bit 2 splits banks, 0x000 and 0x008 collide; R5 first win is port 0
      put(0, 1'b1, 1'b0, 12'h000, '0);
      put(1, 1'b1, 1'b0, 12'h008, '0);
      cycle();
      chk(acc[0] && !acc[1], "R5 first conflict winner", {acc[1], acc[0]}, 1);
      put(0, 1'b1, 1'b0, 12'h010, '0);   // new bank 0 request, port 1 holds
      cycle();
      chk(acc[1] && !acc[0], "R5 loser wins next", {acc[1], acc[0]}, 2);
      put(1, 1'b0, 1'b0, '0, '0);
      cycle();

      // R1: upper address bits alias
      put(0, 1'b1, 1'b1, 12'h004, 32'hA5A5_0F0F);
      cycle();
      put(0, 1'b1, 1'b0, 12'h804, '0);
      cycle();
      chk(p0_rdata == 32'hA5A5_0F0F, "R1 alias read", p0_rdata, 32'hA5A5_0F0F);

      // random traffic; a refused request is held unchanged
      for (int p = 0; p < 2; p++) acc[p] = 1'b1;
      for (int n = 0; n < 4000; n++) begin
         for (int p = 0; p < 2; p++) begin
            if (acc[p] || !r_v[p])
               put(p, ($urandom % 4) != 0, ($urandom % 3) == 0,
                   AW'($urandom), $urandom);
         end
         cycle();
      end
      chk(int'(conflict_cycles) == CMAX, "R8 saturated", conflict_cycles, CMAX);

      summary();
      $finish;
   end
endmodule